// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

This block guards a processor core against software that stops making progress. A free-running time base counter produces a one-cycle expiry event whenever a chosen counter bit rises. Each expiry moves a two-bit escalation state forward. The first bit is an arming flag and the second is a pending-interrupt flag. The first expiry sets the arming flag. The next expiry sets the pending flag, which raises the watchdog interrupt when it is enabled. A further expiry with both flags still set issues a one-cycle reset request of the kind that software chose in advance.

Healthy software keeps the block quiet by clearing the arming flag more often than one period. Its interrupt handler clears the pending flag. Both flags are cleared by writing ones to them. When a reset request is issued, the block records which kind it was. It then empties the reset-kind field, so that no second watchdog reset can follow until software chooses a reset kind again.

Top module: `wdog_escalator`

## Requirements
- R1: After reset is released, a time base counter increments on every clock. An expiry event occurs in the cycle in which bit TAPS[p] of the counter becomes 1, where p is the 2-bit period field. The default taps are 4, 6, 8 and 10 for p = 0, 1, 2 and 3, so with p = 0 the first expiry acts on the 17th rising edge after release and later expiries follow every 32 cycles.
- R2: An expiry while the arming flag (sts_arm) is 0 sets the arming flag, whatever the pending flag holds.
- R3: An expiry while sts_arm is 1 and the pending flag (sts_irq) is 0 sets sts_irq.
- R4: wd_irq is 1 exactly when sts_irq, the control interrupt-enable bit and crit_en are all 1.
- R5: An expiry while sts_arm and sts_irq are both 1 and the reset-kind field is nonzero raises, for exactly one cycle, one reset request selected by the field. Code 01 drives rst_core, 10 drives rst_chip and 11 drives rst_sys. The arming and pending flags keep their values.
- R6: When a reset request is issued, the reset-kind code in force is copied into sts_cause and the reset-kind field becomes 00.
- R7: With the reset-kind field at 00, an expiry while both flags are set issues no reset request and leaves both flags unchanged.
- R8: A status write (sts_wr) clears sts_arm where sts_clr_arm is 1 and clears sts_irq where sts_clr_irq is 1. Zeros leave the flags alone. A clear in the same cycle as an expiry that would set the flag wins, and the flag reads 0.
- R9: A control write (ctl_wr) always updates the interrupt enable and the period field. It updates the reset-kind field only while that field is 00. Otherwise the written code is ignored.
- R10: Reset (rst_n low) clears the counter, both flags, sts_cause, all control fields and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_irq_en | input | 1 | Write data: watchdog interrupt enable |
| ctl_rst_sel | input | 2 | Write data: reset kind (00 none, 01 core, 10 chip, 11 system) |
| ctl_period | input | 2 | Write data: period select |
| sts_wr | input | 1 | Status write strobe (write-one-to-clear) |
| sts_clr_arm | input | 1 | Write data: 1 clears the arming flag |
| sts_clr_irq | input | 1 | Write data: 1 clears the pending flag |
| crit_en | input | 1 | External critical-interrupt enable |
| wd_irq | output | 1 | Watchdog interrupt |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |
| sts_arm | output | 1 | Arming flag readback |
| sts_irq | output | 1 | Pending flag readback |
| sts_cause | output | 2 | Kind of the last watchdog reset |
| ctl_irq_en_q | output | 1 | Interrupt enable readback |
| ctl_rst_sel_q | output | 2 | Reset-kind field readback |
| ctl_period_q | output | 2 | Period field readback |

## Verification
The hardest situation to reach is a software clear that lands in the very cycle of an expiry. This is where the priority of the clear over the hardware set is decided. The bench keeps its own copy of the time base and can tell, one cycle ahead, when the next expiry will act. It drives the status write into exactly that cycle, once against the arming set. It also exercises the lock on the reset-kind field and a keep-alive loop that never lets the pending flag rise. Each full escalation is run with a different reset kind and period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int PSEL_W   = 2;
   localparam int NUM_TAPS = 1 << PSEL_W;
   localparam int TAP_FW   = 8;

   typedef enum logic [1:0] {
      RST_NONE = 2'b00,
      RST_CORE = 2'b01,
      RST_CHIP = 2'b10,
      RST_SYS  = 2'b11
   } rst_sel_e;

   typedef struct packed {
      logic              irq_en;
      rst_sel_e          rst_sel;
      logic [PSEL_W-1:0] period;
   } ctl_t;
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase
   import wdog_pkg::*;
#(
   parameter int                         TB_W = 32,
   parameter logic [NUM_TAPS*TAP_FW-1:0] TAPS = {8'd10, 8'd8, 8'd6, 8'd4}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PSEL_W-1:0] period,
   output logic              expire
);
   if (TB_W < 2) begin : g_bad_width
      $error("wdog_timebase: TB_W must be at least 2");
   end

   logic [TB_W-1:0]     cnt;
   logic [NUM_TAPS-1:0] hit;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      localparam int K = int'(TAPS[g*TAP_FW +: TAP_FW]);
      if (K >= TB_W) begin : g_bad_tap
         $error("wdog_timebase: tap position beyond counter width");
      end
      localparam logic [TB_W-1:0] BIT_K  = TB_W'(1) << K;
      localparam logic [TB_W-1:0] MASK_K = (TB_W'(2) << K) - TB_W'(1);
      // The bit has just risen when it is set and every bit below it is clear.
      assign hit[g] = (cnt & MASK_K) == BIT_K;
   end

   assign expire = hit[period];

   // R1
   single_cycle_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (!expire || period != $past(period)));
endmodule

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
   import wdog_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  ctl_t wr_data,
   input  logic clr_sel,
   output ctl_t q
);
   logic sel_open;
   assign sel_open = (q.rst_sel == RST_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (wr) begin
            q.irq_en <= wr_data.irq_en;
            q.period <= wr_data.period;
         end
         if (clr_sel)              q.rst_sel <= RST_NONE;
         else if (wr && sel_open)  q.rst_sel <= wr_data.rst_sel;
      end
   end

   // R9
   sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sel_open) |=> (q.rst_sel == $past(q.rst_sel) || q.rst_sel == RST_NONE));

   // R6
   sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sel |=> q.rst_sel == RST_NONE);
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
   import wdog_pkg::*;
#(
   parameter int NUM_RST = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     expire,
   input  rst_sel_e rst_sel,
   input  logic     irq_en,
   input  logic     crit_en,
   input  logic     sts_wr,
   input  logic     clr_arm,
   input  logic     clr_irq,
   output logic     arm,
   output logic     pend,
   output rst_sel_e cause,
   output logic     fire,
   output logic     wd_irq,
   output logic [NUM_RST-1:0] rst_req
);
   if (NUM_RST != 3) begin : g_bad_count
      $error("wdog_escalate: three reset kinds are encoded");
   end

   typedef enum logic [1:0] {STEP_NONE, STEP_ARM, STEP_PEND, STEP_FIRE} step_e;

   step_e step;
   logic  arm_d, pend_d, wclr_arm, wclr_irq;

   assign wclr_arm = sts_wr && clr_arm;
   assign wclr_irq = sts_wr && clr_irq;

   always_comb begin
      step = STEP_NONE;
      if (expire) begin
         if (!arm)                      step = STEP_ARM;
         else if (!pend)                step = STEP_PEND;
         else if (rst_sel != RST_NONE)  step = STEP_FIRE;
      end
   end

   assign fire = (step == STEP_FIRE);

   always_comb begin
      arm_d  = arm  || (step == STEP_ARM);
      pend_d = pend || (step == STEP_PEND);
      if (wclr_arm) arm_d  = 1'b0;
      if (wclr_irq) pend_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm   <= 1'b0;
         pend  <= 1'b0;
         cause <= RST_NONE;
      end else begin
         arm  <= arm_d;
         pend <= pend_d;
         if (fire) cause <= rst_sel;
      end
   end

   for (genvar r = 0; r < NUM_RST; r++) begin : g_req
      always_ff @(posedge clk) begin
         if (!rst_n) rst_req[r] <= 1'b0;
         else        rst_req[r] <= fire && (rst_sel == rst_sel_e'(r + 1));
      end
   end

   assign wd_irq = pend && irq_en && crit_en;

   // R2
   arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !arm && !wclr_arm) |=> arm);

   // R3
   pend_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(arm));

   // R5
   one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rst_req));

   // R5
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rst_req) |=> !(|rst_req));

   // R6
   cause_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rst_req) |-> cause == $past(rst_sel));

   // R8
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wclr_irq |=> !pend);
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
   import wdog_pkg::*;
#(
   parameter int                         TB_W = 32,
   parameter logic [NUM_TAPS*TAP_FW-1:0] TAPS = {8'd10, 8'd8, 8'd6, 8'd4}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic       ctl_irq_en,
   input  logic [1:0] ctl_rst_sel,
   input  logic [1:0] ctl_period,
   input  logic       sts_wr,
   input  logic       sts_clr_arm,
   input  logic       sts_clr_irq,
   input  logic       crit_en,
   output logic       wd_irq,
   output logic       rst_core,
   output logic       rst_chip,
   output logic       rst_sys,
   output logic       sts_arm,
   output logic       sts_irq,
   output logic [1:0] sts_cause,
   output logic       ctl_irq_en_q,
   output logic [1:0] ctl_rst_sel_q,
   output logic [1:0] ctl_period_q
);
   localparam int NUM_RST = 3;

   ctl_t               wdata, ctl_q;
   logic               expire, fire;
   rst_sel_e           cause;
   logic [NUM_RST-1:0] req;

   assign wdata.irq_en  = ctl_irq_en;
   assign wdata.rst_sel = rst_sel_e'(ctl_rst_sel);
   assign wdata.period  = ctl_period;

   wdog_timebase #(.TB_W(TB_W), .TAPS(TAPS)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (ctl_q.period),
      .expire (expire)
   );

   wdog_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ctl_wr),
      .wr_data (wdata),
      .clr_sel (fire),
      .q       (ctl_q)
   );

   wdog_escalate #(.NUM_RST(NUM_RST)) u_esc (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .rst_sel (ctl_q.rst_sel),
      .irq_en  (ctl_q.irq_en),
      .crit_en (crit_en),
      .sts_wr  (sts_wr),
      .clr_arm (sts_clr_arm),
      .clr_irq (sts_clr_irq),
      .arm     (sts_arm),
      .pend    (sts_irq),
      .cause   (cause),
      .fire    (fire),
      .wd_irq  (wd_irq),
      .rst_req (req)
   );

   assign rst_core      = req[0];
   assign rst_chip      = req[1];
   assign rst_sys       = req[2];
   assign sts_cause     = cause;
   assign ctl_irq_en_q  = ctl_q.irq_en;
   assign ctl_rst_sel_q = ctl_q.rst_sel;
   assign ctl_period_q  = ctl_q.period;
endmodule

// File: tb/sim_wdog_escalator.sv
module sim_wdog_escalator;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 0, ctl_irq_en = 0, sts_wr = 0, sts_clr_arm = 0, sts_clr_irq = 0, crit_en = 0;
   logic [1:0] ctl_rst_sel = 0, ctl_period = 0;
   logic wd_irq, rst_core, rst_chip, rst_sys, sts_arm, sts_irq, ctl_irq_en_q;
   logic [1:0] sts_cause, ctl_rst_sel_q, ctl_period_q;

   int total = 0, bad = 0;
   bit cmp_on = 0;
   int n_core = 0, n_chip = 0, n_sys = 0;

   always #2 clk = ~clk;

   wdog_escalator u0 (.*);

   // reference model
   int unsigned mcnt;
   bit m_arm, m_irq, m_ien, m_rc, m_rch, m_rs;
   bit [1:0] m_cause, m_code, m_per;
   int taps [4] = '{4, 6, 8, 10};

   function automatic bit exp_next();
      int unsigned k, mask;
      k = taps[m_per];
      mask = (k == 31) ? 32'hFFFF_FFFF : ((32'd2 << k) - 1);
      return (mcnt & mask) == (32'd1 << k);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mcnt = 0; m_arm = 0; m_irq = 0; m_ien = 0; m_cause = 0; m_code = 0; m_per = 0;
         m_rc = 0; m_rch = 0; m_rs = 0;
      end else begin
         bit e, fired, na, ni;
         e = exp_next(); fired = 0; na = m_arm; ni = m_irq;
         m_rc = 0; m_rch = 0; m_rs = 0;
         if (e) begin
            if (!m_arm) na = 1;
            else if (!m_irq) ni = 1;
            else if (m_code != 0) begin
               fired = 1;
               m_rc = (m_code == 1); m_rch = (m_code == 2); m_rs = (m_code == 3);
               m_cause = m_code;
            end
         end
         if (sts_wr && sts_clr_arm) na = 0;
         if (sts_wr && sts_clr_irq) ni = 0;
         m_arm = na; m_irq = ni;
         if (ctl_wr) begin
            m_ien = ctl_irq_en; m_per = ctl_period;
            if (m_code == 0) m_code = ctl_rst_sel;
         end
         if (fired) m_code = 0;
         mcnt = mcnt + 1;
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         n_core += int'(rst_core); n_chip += int'(rst_chip); n_sys += int'(rst_sys);
      end
      if (cmp_on && rst_n) begin
         chk(sts_arm == m_arm, "R2", "arm (R1 timing)", sts_arm, m_arm);
         chk(sts_irq == m_irq, "R3", "pending", sts_irq, m_irq);
         chk(wd_irq == (m_irq && m_ien && crit_en), "R4", "wd_irq", wd_irq, m_irq && m_ien && crit_en);
         chk({rst_sys, rst_chip, rst_core} == {m_rs, m_rch, m_rc}, "R5", "reset reqs",
             {rst_sys, rst_chip, rst_core}, {m_rs, m_rch, m_rc});
         chk(sts_cause == m_cause, "R6", "cause", sts_cause, m_cause);
         chk(ctl_rst_sel_q == m_code, "R9", "reset kind", ctl_rst_sel_q, m_code);
         chk({ctl_irq_en_q, ctl_period_q} == {m_ien, m_per}, "R9", "ien/period",
             {ctl_irq_en_q, ctl_period_q}, {m_ien, m_per});
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl_write(bit ien, bit [1:0] sel, bit [1:0] per);
      ctl_wr = 1; ctl_irq_en = ien; ctl_rst_sel = sel; ctl_period = per;
      tick(1);
      ctl_wr = 0;
   endtask

   task automatic sts_clear(bit a, bit i);
      sts_wr = 1; sts_clr_arm = a; sts_clr_irq = i;
      tick(1);
      sts_wr = 0; sts_clr_arm = 0; sts_clr_irq = 0;
   endtask

   task automatic wait_exp();
      int guard = 0;
      while (!exp_next() && guard < 5000) begin tick(1); guard++; end
   endtask

   task automatic wait_pulse();
      int guard = 0;
      while (!(m_rc || m_rch || m_rs) && guard < 12000) begin tick(1); guard++; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      // R10 reset state
      chk({sts_arm, sts_irq, sts_cause, wd_irq, rst_core, rst_chip, rst_sys} == 0, "R10",
          "status/outputs", {sts_arm, sts_irq, sts_cause, wd_irq, rst_core, rst_chip, rst_sys}, 0);
      chk({ctl_irq_en_q, ctl_rst_sel_q, ctl_period_q} == 0, "R10", "control",
          {ctl_irq_en_q, ctl_rst_sel_q, ctl_period_q}, 0);
      rst_n = 1; cmp_on = 1;
      // R1 first expiry on the 17th edge
      tick(16);
      chk(sts_arm == 0, "R1", "arm before first expiry", sts_arm, 0);
      tick(1);
      chk(sts_arm == 1, "R1", "arm after first expiry", sts_arm, 1);

      crit_en = 1;
      ctl_write(1, 2'b01, 2'd0);
      wait_exp(); tick(1);
      chk(sts_irq == 1, "R3", "pending set", sts_irq, 1);
      chk(wd_irq == 1, "R4", "irq raised", wd_irq, 1);
      crit_en = 0; tick(1);
      chk(wd_irq == 0, "R4", "irq masked by crit_en", wd_irq, 0);
      crit_en = 1;

      wait_pulse();
      chk(rst_core == 1 && rst_chip == 0 && rst_sys == 0, "R5", "core pulse",
          {rst_sys, rst_chip, rst_core}, 1);
      chk(sts_arm && sts_irq, "R5", "flags held", {sts_arm, sts_irq}, 3);
      chk(sts_cause == 2'b01 && ctl_rst_sel_q == 0, "R6", "cause/kind",
          {sts_cause, ctl_rst_sel_q}, 4);
      tick(1);
      chk(rst_core == 0, "R5", "pulse width", rst_core, 0);

      // R7 kind 00: nothing happens
      begin
         int c0;
         c0 = n_core + n_chip + n_sys;
         repeat (3) begin wait_exp(); tick(1); end
         chk(n_core + n_chip + n_sys == c0, "R7", "no pulses", n_core + n_chip + n_sys, c0);
         chk(sts_arm && sts_irq, "R7", "flags unchanged", {sts_arm, sts_irq}, 3);
      end

      // R8 write-one-to-clear
      sts_clear(0, 0);
      chk(sts_arm && sts_irq, "R8", "zeros ignored", {sts_arm, sts_irq}, 3);
      sts_clear(0, 1);
      chk(sts_arm == 1 && sts_irq == 0, "R8", "irq cleared only", {sts_arm, sts_irq}, 2);
      sts_clear(1, 0);
      chk(sts_arm == 0, "R8", "arm cleared", sts_arm, 0);

      // R9 lock on reset kind
      ctl_write(1, 2'b10, 2'd1);
      ctl_write(0, 2'b11, 2'd1);
      chk(ctl_rst_sel_q == 2'b10, "R9", "kind locked", ctl_rst_sel_q, 2);
      chk(ctl_irq_en_q == 0, "R9", "enable still writable", ctl_irq_en_q, 0);
      ctl_write(1, 2'b11, 2'd1);

      // R8 clear collides with expiry
      wait_exp();
      sts_wr = 1; sts_clr_arm = 1;
      tick(1);
      sts_wr = 0; sts_clr_arm = 0;
      chk(sts_arm == 0, "R8", "clear wins over set", sts_arm, 0);

      wait_pulse();
      chk(rst_chip == 1 && rst_core == 0 && rst_sys == 0, "R5", "chip pulse",
          {rst_sys, rst_chip, rst_core}, 2);
      chk(sts_cause == 2'b10, "R6", "chip cause", sts_cause, 2);

      // R8 keep-alive
      sts_clear(1, 1);
      ctl_write(1, 2'b11, 2'd0);
      for (int i = 0; i < 12; i++) begin
         tick(20);
         sts_clear(1, 0);
         chk(sts_irq == 0, "R8", "keep-alive holds off pending", sts_irq, 0);
      end

      ctl_write(1, 2'b11, 2'd3);
      wait_pulse();
      chk(rst_sys == 1 && rst_core == 0 && rst_chip == 0, "R5", "system pulse",
          {rst_sys, rst_chip, rst_core}, 4);
      chk(sts_cause == 2'b11 && ctl_rst_sel_q == 0, "R6", "system cause",
          {sts_cause, ctl_rst_sel_q}, 12);
      tick(4);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule